// File: doc/BRIEF.md
# Cycle-Stealing Single-Channel DMA Engine

This block moves a block of words between a peripheral and memory over a bus it shares with the processor. Software sets up a transfer through four small registers: the direction, a fixed device address, a memory start address and a word count. It then issues a start command. The engine borrows the bus one word at a time. For each word it raises a request and waits for the grant. It then performs exactly one bus transaction and releases the request. Because the engine sits apart from both the device and the memory, every word takes two tenures: a fetch from the source into an internal holding register, then a store from that register to the destination.

An external arbiter grants the bus only when the processor is between its own bus cycles, so the processor is delayed at most one transaction per grant. When the count runs out, the engine goes idle and raises a completion flag, which is also the interrupt. The flag stays set until software clears it. A start with a count of zero completes at once and never touches the bus.

The controller has seven states:
- `ST_IDLE`
- `ST_FETCH_REQ`, `ST_FETCH_BUS`, `ST_FETCH_REL`
- `ST_STORE_REQ`, `ST_STORE_BUS`, `ST_STORE_REL`

Its transitions are:
- IDLE→FETCH_REQ on a start with a non-zero count; IDLE stays put on a start with a zero count and completes at once.
- FETCH_REQ→FETCH_BUS on grant.
- FETCH_BUS→FETCH_REL on acknowledge.
- FETCH_REL→STORE_REQ unconditionally.
- STORE_REQ→STORE_BUS on grant.
- STORE_BUS→STORE_REL on acknowledge.
- STORE_REL→FETCH_REQ while words remain, or STORE_REL→IDLE, setting the completion flag, when the count is zero.

Top module: `cs_dma`

## Requirements
- R1: After reset, bus_req and irq are 0, and the status register (index 0) reads busy (bit 1) = 0 and done (bit 2) = 0.
- R2: Register indices are: 1 = device address, 2 = memory address, 3 = word count. While idle, a write to one of them is read back unchanged. While busy, writes to these indices are ignored.
- R3: A start (index 0 write with bit 1 set) with a non-zero count sets busy and raises bus_req. The engine drives m_en only after a cycle with bus_req high, and only while bus_grant is high.
- R4: Index 0 bit 0 selects the direction: 0 = device to memory, 1 = memory to device. On the bus, m_dev = 1 selects device space and m_we = 1 marks a write. For each word, the engine first reads the source, then writes the destination.
- R5: In the cycle after each acknowledged transaction (m_en and m_ack both high), bus_req is 0.
- R6: Each grant tenure carries exactly one transaction: m_en is low in the cycle after an acknowledge.
- R7: The word written to the destination equals the word read from the source in the same word step.
- R8: After each word, the memory address increments by one and the count decrements by one. The device address does not change.
- R9: When the last word is stored, busy clears and done and irq rise. They stay high until cleared.
- R10: A start with a count of 0 sets done in the next cycle and never raises bus_req.
- R11: An index 0 write with bit 2 set clears done and irq. If completion occurs in the same cycle, done stays set.
- R12: A start issued while busy is ignored: no extra bus transactions occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register index |
| cfg_wdata | input | DATA_W | Register write data |
| cfg_rdata | output | DATA_W | Register read data for cfg_addr |
| bus_req | output | 1 | Bus request to arbiter |
| bus_grant | input | 1 | Bus grant from arbiter |
| m_en | output | 1 | Transaction valid while the engine owns the bus |
| m_we | output | 1 | 1 = write, 0 = read |
| m_dev | output | 1 | 1 = device space, 0 = memory space |
| m_addr | output | ADDR_W | Transaction address |
| m_wdata | output | DATA_W | Write data |
| m_rdata | input | DATA_W | Read data, valid with m_ack |
| m_ack | input | 1 | Transaction complete |
| irq | output | 1 | Completion interrupt |

## Verification
The two events that can meet in one cycle are the engine's completion, which sets done, and a software clear of that same flag. The bench provokes this in two ways:
- It issues one register write that carries start and clear together while the count is zero, so the immediate completion and the clear share an edge.
- It times a clear write to land on the edge where the final store's release state sets done.

In both cases done and irq must read 1 afterwards. A separate plain clear must still drop them.

// File: rtl/cs_dma_pkg.sv
package cs_dma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_REQ,
        ST_FETCH_BUS,
        ST_FETCH_REL,
        ST_STORE_REQ,
        ST_STORE_BUS,
        ST_STORE_REL
    } dma_state_t;

    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_DEV  = 2'd1;
    localparam logic [1:0] REG_MEM  = 2'd2;
    localparam logic [1:0] REG_CNT  = 2'd3;

    localparam int CTRL_DIR_BIT  = 0;
    localparam int CTRL_GO_BIT   = 1;
    localparam int CTRL_CLR_BIT  = 2;
    localparam int STAT_BUSY_BIT = 1;
    localparam int STAT_DONE_BIT = 2;

    localparam logic DIR_DEV2MEM = 1'b0;
    localparam logic DIR_MEM2DEV = 1'b1;

endpackage

// File: rtl/cs_dma_regs.sv
module cs_dma_regs
    import cs_dma_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              busy,
    input  logic              done_set,
    input  logic              dir,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [CNT_W-1:0]  count,
    output logic              ld_dir,
    output logic              ld_dev,
    output logic              ld_mem,
    output logic              ld_cnt,
    output logic              go,
    output logic              done
);

    logic wr_ctrl;
    logic clr;

    always_comb begin
        wr_ctrl = cfg_we && (cfg_addr == REG_CTRL);
        go      = wr_ctrl && cfg_wdata[CTRL_GO_BIT] && !busy;
        ld_dir  = go;
        clr     = wr_ctrl && cfg_wdata[CTRL_CLR_BIT];
        ld_dev  = cfg_we && (cfg_addr == REG_DEV) && !busy;
        ld_mem  = cfg_we && (cfg_addr == REG_MEM) && !busy;
        ld_cnt  = cfg_we && (cfg_addr == REG_CNT) && !busy;
    end

    // completion wins over a clear or a restart arriving in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          done <= 1'b0;
        else if (done_set)   done <= 1'b1;
        else if (clr || go)  done <= 1'b0;
    end

    always_comb begin
        cfg_rdata = '0;
        unique case (cfg_addr)
            REG_CTRL: begin
                cfg_rdata[CTRL_DIR_BIT]  = dir;
                cfg_rdata[STAT_BUSY_BIT] = busy;
                cfg_rdata[STAT_DONE_BIT] = done;
            end
            REG_DEV: cfg_rdata = DATA_W'(dev_addr);
            REG_MEM: cfg_rdata = DATA_W'(mem_addr);
            REG_CNT: cfg_rdata = DATA_W'(count);
            default: cfg_rdata = '0;
        endcase
    end

    p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_set |=> done)
        else $error("completion lost against clear");

endmodule

// File: rtl/cs_dma_datapath.sv
module cs_dma_datapath #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ld_dir,
    input  logic              ld_dev,
    input  logic              ld_mem,
    input  logic              ld_cnt,
    input  logic              busy,
    input  logic              cap,
    input  logic              step,
    input  logic [DATA_W-1:0] m_rdata,
    output logic              dir,
    output logic [ADDR_W-1:0] dev_addr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [CNT_W-1:0]  count,
    output logic [DATA_W-1:0] hold,
    output logic              cnt_zero
);

    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);
    localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir      <= 1'b0;
            dev_addr <= '0;
        end else begin
            if (ld_dir) dir      <= wdata[0];
            if (ld_dev) dev_addr <= ADDR_W'(wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mem_addr <= '0;
        else if (ld_mem)  mem_addr <= ADDR_W'(wdata);
        else if (step)    mem_addr <= mem_addr + ADDR_ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       count <= '0;
        else if (ld_cnt)  count <= CNT_W'(wdata);
        else if (step)    count <= count - CNT_ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    hold <= '0;
        else if (cap)  hold <= m_rdata;
    end

    assign cnt_zero = (count == '0);

    p_dev_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(dev_addr))
        else $error("device address changed during transfer");

    p_addr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (mem_addr == $past(mem_addr) + ADDR_ONE) && (count == $past(count) - CNT_ONE))
        else $error("address/count step wrong");

    p_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> hold == $past(m_rdata))
        else $error("holding register missed fetched word");

endmodule

// File: rtl/cs_dma_fsm.sv
module cs_dma_fsm
    import cs_dma_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              cnt_zero,
    input  logic              dir,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] hold,
    input  logic              bus_grant,
    input  logic              m_ack,
    output logic              busy,
    output logic              done_set,
    output logic              cap,
    output logic              step,
    output logic              bus_req,
    output logic              m_en,
    output logic              m_we,
    output logic              m_dev,
    output logic [ADDR_W-1:0] m_addr,
    output logic [DATA_W-1:0] m_wdata
);

    dma_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:      if (go && !cnt_zero) state_nx = ST_FETCH_REQ;
            ST_FETCH_REQ: if (bus_grant)       state_nx = ST_FETCH_BUS;
            ST_FETCH_BUS: if (bus_grant && m_ack) state_nx = ST_FETCH_REL;
            ST_FETCH_REL: state_nx = ST_STORE_REQ;
            ST_STORE_REQ: if (bus_grant)       state_nx = ST_STORE_BUS;
            ST_STORE_BUS: if (bus_grant && m_ack) state_nx = ST_STORE_REL;
            ST_STORE_REL: state_nx = cnt_zero ? ST_IDLE : ST_FETCH_REQ;
            default:      state_nx = ST_IDLE;
        endcase
    end

    logic fetch_side_dev;
    logic on_bus;

    always_comb begin
        fetch_side_dev = (dir == DIR_DEV2MEM);
        busy     = (state != ST_IDLE);
        bus_req  = 1'b0;
        on_bus   = 1'b0;
        m_we     = 1'b0;
        m_dev    = 1'b0;
        m_addr   = '0;
        m_wdata  = '0;
        done_set = 1'b0;
        unique case (state)
            ST_IDLE: done_set = go && cnt_zero;
            ST_FETCH_REQ, ST_STORE_REQ: bus_req = 1'b1;
            ST_FETCH_BUS: begin
                bus_req = 1'b1;
                on_bus  = bus_grant;
                m_dev   = on_bus && fetch_side_dev;
                m_addr  = !on_bus ? '0 : (fetch_side_dev ? dev_addr : mem_addr);
            end
            ST_STORE_BUS: begin
                bus_req = 1'b1;
                on_bus  = bus_grant;
                m_we    = on_bus;
                m_dev   = on_bus && !fetch_side_dev;
                m_addr  = !on_bus ? '0 : (fetch_side_dev ? mem_addr : dev_addr);
                m_wdata = on_bus ? hold : '0;
            end
            ST_FETCH_REL: ;
            ST_STORE_REL: done_set = cnt_zero;
            default: ;
        endcase
        m_en = on_bus;
        cap  = (state == ST_FETCH_BUS) && on_bus && m_ack;
        step = (state == ST_STORE_BUS) && on_bus && m_ack;
    end

    p_req_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(m_en) |-> $past(bus_req))
        else $error("bus driven without prior request");

    p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (m_en && m_ack) |=> !bus_req)
        else $error("request held after transaction");

    p_one_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (m_en && m_ack) |=> !m_en)
        else $error("second transaction in one tenure");

    p_zero_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && go && cnt_zero) |=> !bus_req)
        else $error("zero-count start requested bus");

endmodule

// File: rtl/cs_dma.sv
module cs_dma
    import cs_dma_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic              bus_req,
    input  logic              bus_grant,
    output logic              m_en,
    output logic              m_we,
    output logic              m_dev,
    output logic [ADDR_W-1:0] m_addr,
    output logic [DATA_W-1:0] m_wdata,
    input  logic [DATA_W-1:0] m_rdata,
    input  logic              m_ack,
    output logic              irq
);

    logic              busy, done_set, done, go;
    logic              ld_dir, ld_dev, ld_mem, ld_cnt;
    logic              cap, step, cnt_zero, dir;
    logic [ADDR_W-1:0] dev_addr, mem_addr;
    logic [CNT_W-1:0]  count;
    logic [DATA_W-1:0] hold;

    cs_dma_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .busy(busy), .done_set(done_set), .dir(dir),
        .dev_addr(dev_addr), .mem_addr(mem_addr), .count(count),
        .ld_dir(ld_dir), .ld_dev(ld_dev), .ld_mem(ld_mem), .ld_cnt(ld_cnt),
        .go(go), .done(done)
    );

    cs_dma_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_path (
        .clk(clk), .rst_n(rst_n), .wdata(cfg_wdata),
        .ld_dir(ld_dir), .ld_dev(ld_dev), .ld_mem(ld_mem), .ld_cnt(ld_cnt),
        .busy(busy), .cap(cap), .step(step), .m_rdata(m_rdata),
        .dir(dir), .dev_addr(dev_addr), .mem_addr(mem_addr), .count(count),
        .hold(hold), .cnt_zero(cnt_zero)
    );

    cs_dma_fsm #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .go(go), .cnt_zero(cnt_zero), .dir(dir),
        .dev_addr(dev_addr), .mem_addr(mem_addr), .hold(hold),
        .bus_grant(bus_grant), .m_ack(m_ack),
        .busy(busy), .done_set(done_set), .cap(cap), .step(step),
        .bus_req(bus_req), .m_en(m_en), .m_we(m_we), .m_dev(m_dev),
        .m_addr(m_addr), .m_wdata(m_wdata)
    );

    assign irq = done;

    p_irq_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> !busy)
        else $error("interrupt raised while still busy");

endmodule

// File: tb/cs_dma_tb.sv
`timescale 1ns/1ps
module cs_dma_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        bus_req, bus_grant = 1'b0;
    logic        m_en, m_we, m_dev;
    logic [15:0] m_addr, m_wdata;
    logic [15:0] m_rdata = '0;
    logic        m_ack = 1'b0;
    logic        irq;

    always #2.5 clk = ~clk;

    cs_dma u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .bus_req(bus_req),
        .bus_grant(bus_grant), .m_en(m_en), .m_we(m_we), .m_dev(m_dev),
        .m_addr(m_addr), .m_wdata(m_wdata), .m_rdata(m_rdata), .m_ack(m_ack),
        .irq(irq)
    );

    typedef struct packed {
        logic        we;
        logic        dev;
        logic [15:0] addr;
        logic [15:0] data;
    } xact_t;

    xact_t exp_q[$];
    int n_chk = 0, n_fail = 0;
    int grant_delay = 0, ack_lat = 0;
    int gcnt = 0, wcnt = 0;
    logic [15:0] dev_seq = '0, exp_dev_seq = '0;
    logic [15:0] mem_model [256];
    logic rel_check = 1'b0;
    logic last_ack_seen = 1'b0;

    function automatic logic [15:0] mem_init(input logic [7:0] a);
        return 16'h5000 + 16'(a) * 16'd3;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // arbiter: grant after the processor's current bus cycles finish
    always @(negedge clk) begin
        if (!bus_req) begin
            bus_grant = 1'b0;
            gcnt = 0;
        end else if (!bus_grant) begin
            if (gcnt >= grant_delay) bus_grant = 1'b1;
            else gcnt++;
        end
    end

    // responder and scoreboard monitor
    always @(negedge clk) begin
        xact_t got, exp;
        if (rel_check) begin
            check(!bus_req, "R5 request released after ack", {31'd0, bus_req}, 32'd0);
            check(!m_en, "R6 single transaction per grant", {31'd0, m_en}, 32'd0);
            rel_check = 1'b0;
        end
        if (m_en) begin
            if (wcnt >= ack_lat) begin
                if (!m_we) begin
                    if (m_dev) begin
                        m_rdata = {4'h9, dev_seq[11:0]};
                        dev_seq++;
                    end else begin
                        m_rdata = mem_model[m_addr[7:0]];
                    end
                end else if (!m_dev) begin
                    mem_model[m_addr[7:0]] = m_wdata;
                end
                got = '{we: m_we, dev: m_dev, addr: m_addr, data: (m_we ? m_wdata : m_rdata)};
                if (exp_q.size() == 0) begin
                    check(1'b0, "R12 unexpected transaction", {got.addr, got.data}, 32'd0);
                end else begin
                    exp = exp_q.pop_front();
                    check(got == exp, got.we ? "R7 stored word" : "R4 fetch transaction",
                          {got.addr, got.data}, {exp.addr, exp.data});
                    check({got.we, got.dev} == {exp.we, exp.dev}, "R4 direction/space",
                          {30'd0, got.we, got.dev}, {30'd0, exp.we, exp.dev});
                    if (exp_q.size() == 0) last_ack_seen = 1'b1;
                end
                m_ack = 1'b1;
                rel_check = 1'b1;
                wcnt = 0;
            end else begin
                m_ack = 1'b0;
                wcnt++;
            end
        end else begin
            m_ack = 1'b0;
            wcnt = 0;
        end
    end

    task automatic cfg_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    // driver: program the engine and push the expected bus traffic
    task automatic program_xfer(input logic dir, input logic [15:0] dev, input logic [15:0] mem,
                                input int n);
        logic [15:0] v;
        cfg_write(2'd1, dev);
        cfg_write(2'd2, mem);
        cfg_write(2'd3, 16'(n));
        for (int k = 0; k < n; k++) begin
            if (dir == 1'b0) begin
                v = {4'h9, exp_dev_seq[11:0]};
                exp_dev_seq++;
                exp_q.push_back('{we: 1'b0, dev: 1'b1, addr: dev, data: v});
                exp_q.push_back('{we: 1'b1, dev: 1'b0, addr: mem + 16'(k), data: v});
            end else begin
                v = mem_init(8'(mem + 16'(k)));
                exp_q.push_back('{we: 1'b0, dev: 1'b0, addr: mem + 16'(k), data: v});
                exp_q.push_back('{we: 1'b1, dev: 1'b1, addr: dev, data: v});
            end
        end
    endtask

    task automatic wait_irq();
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (irq) break;
        end
    endtask

    initial begin
        logic [15:0] r;
        for (int i = 0; i < 256; i++) mem_model[i] = mem_init(8'(i));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        check(!bus_req, "R1 bus_req after reset", {31'd0, bus_req}, 32'd0);
        check(!irq, "R1 irq after reset", {31'd0, irq}, 32'd0);
        cfg_read(2'd0, r);
        check(r[2:1] == 2'b00, "R1 status after reset", 32'(r), 32'd0);

        // R2 readback while idle
        cfg_write(2'd1, 16'h0040);
        cfg_write(2'd2, 16'h0020);
        cfg_write(2'd3, 16'd4);
        cfg_read(2'd1, r); check(r == 16'h0040, "R2 device address readback", 32'(r), 32'h40);
        cfg_read(2'd2, r); check(r == 16'h0020, "R2 memory address readback", 32'(r), 32'h20);
        cfg_read(2'd3, r); check(r == 16'd4, "R2 count readback", 32'(r), 32'd4);

        // device to memory, immediate grant and ack
        grant_delay = 0; ack_lat = 0;
        program_xfer(1'b0, 16'h0040, 16'h0020, 4);
        cfg_write(2'd0, 16'h0002);
        check(bus_req, "R3 request after start", {31'd0, bus_req}, 32'd1);
        cfg_read(2'd0, r); check(r[1], "R3 busy after start", 32'(r), 32'h2);
        wait_irq();
        cfg_read(2'd0, r); check(r[2:1] == 2'b10, "R9 done set, busy clear", 32'(r), 32'h4);
        cfg_read(2'd2, r); check(r == 16'h0024, "R8 memory address advanced", 32'(r), 32'h24);
        cfg_read(2'd3, r); check(r == 16'd0, "R8 count exhausted", 32'(r), 32'd0);
        cfg_read(2'd1, r); check(r == 16'h0040, "R8 device address fixed", 32'(r), 32'h40);
        repeat (10) @(negedge clk);
        check(irq, "R9 irq held until cleared", {31'd0, irq}, 32'd1);
        cfg_write(2'd0, 16'h0004);
        check(!irq, "R11 clear drops irq", {31'd0, irq}, 32'd0);

        // memory to device, delayed grant and slow ack; busy writes ignored
        grant_delay = 3; ack_lat = 2;
        program_xfer(1'b1, 16'h0007, 16'h0080, 3);
        cfg_write(2'd0, 16'h0003);
        cfg_write(2'd1, 16'h1234);
        cfg_write(2'd3, 16'd9);
        cfg_write(2'd0, 16'h0002);
        wait_irq();
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R12 no extra transfers after busy start",
              32'(exp_q.size()), 32'd0);
        cfg_read(2'd1, r); check(r == 16'h0007, "R2 busy write to device address ignored", 32'(r), 32'h7);
        cfg_read(2'd3, r); check(r == 16'd0, "R2 busy write to count ignored", 32'(r), 32'd0);
        cfg_read(2'd2, r); check(r == 16'h0083, "R8 memory address after mem-to-dev", 32'(r), 32'h83);
        cfg_write(2'd0, 16'h0004);

        // zero count
        cfg_write(2'd3, 16'd0);
        cfg_write(2'd0, 16'h0002);
        check(irq, "R10 zero count completes next cycle", {31'd0, irq}, 32'd1);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check(!bus_req, "R10 no request on zero count", {31'd0, bus_req}, 32'd0);
        end
        cfg_write(2'd0, 16'h0004);
        check(!irq, "R11 clear after zero count", {31'd0, irq}, 32'd0);

        // start and clear in the same write, count zero
        cfg_write(2'd0, 16'h0006);
        cfg_read(2'd0, r); check(r[2], "R11 completion beats simultaneous clear", 32'(r), 32'h4);
        cfg_write(2'd0, 16'h0004);

        // clear landing on the final completion edge
        grant_delay = 1; ack_lat = 1;
        program_xfer(1'b0, 16'h0011, 16'h0030, 2);
        last_ack_seen = 1'b0;
        cfg_write(2'd0, 16'h0002);
        wait (last_ack_seen);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = 16'h0004;
        @(negedge clk);
        cfg_we = 1'b0;
        check(irq, "R11 done kept when clear meets completion", {31'd0, irq}, 32'd1);
        check(exp_q.size() == 0, "R7 all expected words moved", 32'(exp_q.size()), 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule